// File: doc/BRIEF.md
# Inbound Vendor Message Capture Unit

This block sits at the end of a serial-link receive path. It takes vendor-defined message headers one at a time through a valid/ready handshake. Each header is 16 bytes wide and comes with a one-bit type flag. When the block accepts a header, it latches it into four read-only capture words and sets a received-status bit. The status bit drives an interrupt output. While that bit stays set, the block stops taking headers, so later messages wait upstream in the inbound queue until software clears the bit.

A mask bit changes how messages are handled. While the mask is set, every offered message is consumed at once and nothing is captured. A Type 0 message produces a one-cycle unsupported-request report. A Type 1 message is dropped without any report. Software reaches the capture words, the status bit and the mask bit through a simple word-addressed register port.

Top module: `vendor_msg_capture`

## Requirements
- R1: After reset, all four capture words, the status bit and the mask bit read zero, `irq` and `ur_pulse` are low, and `msg_ready` is high once the two-stage reset release has completed.
- R2: A header accepted (`msg_valid` and `msg_ready` high at a rising edge) while the mask is clear is stored with byte 0 in `msg_hdr[127:120]`. Capture word n, at address 0x340 + 4n, holds bytes 4n to 4n+3 with the lowest-numbered byte in bits 31:24. Status (address 0x330, bit 0) reads 1 from the next cycle.
- R3: The word at 0x348 holds byte 8 in bits 31:24, byte 9 in 23:16, byte 10 in 15:8 and byte 11 in 7:0.
- R4: While the status bit is 1 and the mask is 0, `msg_ready` is low and the capture words do not change.
- R5: Writing a 1 to bit 0 of 0x330 clears the status bit at that edge; writing a 0 leaves it unchanged. Once it is clear, a waiting header is accepted on the next edge.
- R6: `irq` is high exactly when the status bit is 1 and the mask bit is 0.
- R7: With the mask set, a Type 0 message (`msg_type` = 0) is accepted, `ur_pulse` is high for exactly the one cycle after the acceptance edge, and neither the capture words nor the status bit change.
- R8: With the mask set, a Type 1 message (`msg_type` = 1) is accepted and dropped, with no `ur_pulse` and no change to the capture words or the status bit.
- R9: Writes to the capture-word addresses have no effect.
- R10: When a status-clear write and a capturing acceptance fall on the same edge, the new header is stored and the status bit reads 1 afterwards.
- R11: The mask bit is bit 0 of address 0x334. It can be written and read back. Other addresses read zero.
- R12: An acceptance on the same edge as a mask write is handled according to the mask value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Header offered |
| msg_type | input | 1 | 0 = Type 0, 1 = Type 1 |
| msg_hdr | input | 128 | Header, byte 0 in the top bits |
| msg_ready | output | 1 | Header may be taken at this edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Received-message interrupt |
| ur_pulse | output | 1 | Unsupported-request report, one cycle |

## Verification
A write-one to the status bit can land on the same edge as a header acceptance. The bench provokes this by offering a header while ready is high and, in the same cycle, writing 1 to the status bit. It then reads back a set status bit and the new header in the capture words. A mask write can also coincide with an acceptance. The directed sequence and a long random phase both produce these overlaps. A behavioural reference model follows every edge, so each coincidence is judged against it for ready, interrupt, report pulse and read data.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

  // Outcome of one header handshake
  typedef enum logic [1:0] {
    VM_IDLE    = 2'd0,
    VM_CAPTURE = 2'd1,
    VM_REJECT  = 2'd2,
    VM_DISCARD = 2'd3
  } vm_action_e;

  // Message type flag encoding
  localparam logic VM_KIND_T0 = 1'b0;
  localparam logic VM_KIND_T1 = 1'b1;

  // Default register byte offsets
  localparam int unsigned VM_CAP_BASE_DEF  = 32'h340;
  localparam int unsigned VM_STAT_ADDR_DEF = 32'h330;
  localparam int unsigned VM_MASK_ADDR_DEF = 32'h334;

endpackage

// File: rtl/vmc_intake.sv
module vmc_intake
  import vmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msg_valid,
  input  logic       msg_kind,
  input  logic       status_q,
  input  logic       mask_q,
  output logic       msg_ready,
  output vm_action_e action,
  output logic       ur_pulse
);

  logic accept;
  logic ur_d;
  logic ur_q;

  // Handshake and per-type decision
  always_comb begin
    msg_ready = rst_n & (mask_q | ~status_q);
    accept    = msg_valid & msg_ready;
    action    = VM_IDLE;
    if (accept) begin
      if (!mask_q) begin
        action = VM_CAPTURE;
      end else if (msg_kind == VM_KIND_T0) begin
        action = VM_REJECT;
      end else begin
        action = VM_DISCARD;
      end
    end
  end

  always_comb begin
    ur_d = (action == VM_REJECT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ur_q <= 1'b0;
    end else begin
      ur_q <= ur_d;
    end
  end

  assign ur_pulse = ur_q;

  // R7: report pulse lasts a single cycle unless a second rejection follows
  p_ur_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ur_q && !ur_d |=> !ur_q);

endmodule

// File: rtl/vmc_capture.sv
module vmc_capture #(
  parameter int HDR_W  = 128,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [HDR_W-1:0]    hdr_in,
  output logic [HDR_W-1:0]    cap_words
);

  localparam int N_WORDS = HDR_W / DATA_W;

  // Word g holds the header slice starting at byte g*(DATA_W/8); lowest byte on top
  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      word_d = hdr_in[HDR_W-1-g*DATA_W -: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (cap_en) begin
        word_q <= word_d;
      end
    end

    assign cap_words[g*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/vmc_csr.sv
module vmc_csr #(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter int                N_WORDS   = 4,
  parameter logic [ADDR_W-1:0] CAP_BASE  = 12'h340,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h330,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 12'h334
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_set,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic [N_WORDS*DATA_W-1:0] cap_words,
  output logic                      status_q,
  output logic                      mask_q,
  output logic                      irq,
  output logic [DATA_W-1:0]         reg_rdata
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic clr;
  logic mask_we;
  logic status_d;
  logic mask_d;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  // Next-state for the status and mask bits
  always_comb begin
    clr      = reg_wr & (reg_addr == STAT_ADDR) & reg_wdata[0];
    mask_we  = reg_wr & (reg_addr == MASK_ADDR);
    status_d = cap_set | (status_q & ~clr);
    mask_d   = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  assign irq = status_q & ~mask_q;

  // Read decode
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR) begin
      reg_rdata = {{(DATA_W-1){1'b0}}, status_q};
    end else if (reg_addr == MASK_ADDR) begin
      reg_rdata = {{(DATA_W-1){1'b0}}, mask_q};
    end
    for (int i = 0; i < N_WORDS; i++) begin
      if (reg_addr == CAP_BASE + ADDR_W'(i * WORD_BYTES)) begin
        reg_rdata = cap_words[i*DATA_W +: DATA_W];
      end
    end
  end

  // R5: write-one with no new capture leaves the bit clear
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_q && clr && !cap_set |=> !status_q);

  // R10: capture wins over a coincident clear
  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_set && clr |=> status_q);

endmodule

// File: rtl/vendor_msg_capture.sv
module vendor_msg_capture
  import vmc_pkg::*;
#(
  parameter int                HDR_BYTES = 16,
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE  = ADDR_W'(VM_CAP_BASE_DEF),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(VM_STAT_ADDR_DEF),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(VM_MASK_ADDR_DEF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  logic                 msg_type,
  input  logic [HDR_BYTES*8-1:0] msg_hdr,
  output logic                 msg_ready,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq,
  output logic                 ur_pulse
);

  localparam int HDR_W   = HDR_BYTES * 8;
  localparam int N_WORDS = HDR_W / DATA_W;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             status_q;
  logic             mask_q;
  logic             cap_en;
  vm_action_e       action;
  logic [HDR_W-1:0] cap_words;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  vmc_intake u_intake (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .msg_valid (msg_valid),
    .msg_kind  (msg_type),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .msg_ready (msg_ready),
    .action    (action),
    .ur_pulse  (ur_pulse)
  );

  assign cap_en = (action == VM_CAPTURE);

  vmc_capture #(
    .HDR_W  (HDR_W),
    .DATA_W (DATA_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_en    (cap_en),
    .hdr_in    (msg_hdr),
    .cap_words (cap_words)
  );

  vmc_csr #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .N_WORDS   (N_WORDS),
    .CAP_BASE  (CAP_BASE),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) u_csr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_set   (cap_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cap_words (cap_words),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq       (irq),
    .reg_rdata (reg_rdata)
  );

  // R4: a pending unmasked message blocks the handshake
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_q && !mask_q |-> !msg_ready);

  // R4: capture words hold while stalled
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_q && !mask_q |=> $stable(cap_words));

  // R2: an unmasked acceptance sets the status bit
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msg_valid && msg_ready && !mask_q |=> status_q);

  // R7: masked Type 0 produces the report on the next cycle
  p_ur_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msg_valid && msg_ready && mask_q && !msg_type |=> ur_pulse);

  // R7/R8: a report only follows a masked Type 0 acceptance
  p_ur_cause_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ur_pulse |-> $past(msg_valid && msg_ready && mask_q && !msg_type));

  // R8: masked acceptances never touch the capture words
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msg_valid && msg_ready && mask_q |=> $stable(cap_words));

endmodule

// File: tb/vendor_msg_capture_test.sv
`timescale 1ns/1ps
module vendor_msg_capture_test;

  localparam logic [11:0] A_STAT = 12'h330;
  localparam logic [11:0] A_MASK = 12'h334;
  localparam logic [11:0] A_CAP  = 12'h340;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         msg_valid = 1'b0;
  logic         msg_type = 1'b0;
  logic [127:0] msg_hdr = '0;
  logic         reg_wr = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         msg_ready;
  logic [31:0]  reg_rdata;
  logic         irq;
  logic         ur_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vendor_msg_capture uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_type  (msg_type),
    .msg_hdr   (msg_hdr),
    .msg_ready (msg_ready),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .ur_pulse  (ur_pulse)
  );

  function automatic logic [127:0] mk_hdr(int k);
    logic [127:0] h;
    for (int j = 0; j < 16; j++) h[127-8*j -: 8] = 8'(k*16 + j + 1);
    return h;
  endfunction

  function automatic logic [31:0] word_of(int k, int w);
    logic [127:0] h;
    h = mk_hdr(k);
    return h[127-32*w -: 32];
  endfunction

  // Behavioural reference model
  int          rcnt;
  logic        mstat, mmask, mur;
  logic [31:0] mcap [0:3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; mstat = 0; mmask = 0; mur = 0;
      for (int w = 0; w < 4; w++) mcap[w] = '0;
    end else if (rcnt < 2) begin
      rcnt = rcnt + 1;
    end else begin
      logic acc, clr, cap;
      acc = msg_valid && (mmask || !mstat);
      clr = reg_wr && reg_addr == A_STAT && reg_wdata[0];
      cap = acc && !mmask;
      mur = acc && mmask && !msg_type;
      if (cap) for (int w = 0; w < 4; w++) mcap[w] = msg_hdr[127-32*w -: 32];
      mstat = cap || (mstat && !clr);
      if (reg_wr && reg_addr == A_MASK) mmask = reg_wdata[0];
    end
  end

  function automatic logic [31:0] model_rd(logic [11:0] a);
    if (a == A_STAT) return {31'b0, mstat};
    if (a == A_MASK) return {31'b0, mmask};
    for (int w = 0; w < 4; w++) if (a == A_CAP + 12'(4*w)) return mcap[w];
    return '0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && rcnt >= 2 && !done) begin
      chk("R4 ready", 32'(msg_ready), 32'(mmask || !mstat));
      chk("R6 irq", 32'(irq), 32'(mstat && !mmask));
      chk("R7 ur_pulse", 32'(ur_pulse), 32'(mur));
      chk("R2 rdata", reg_rdata, model_rd(reg_addr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(); tick();

    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    for (int w = 0; w < 4; w++) begin
      rd(A_CAP + 12'(4*w), d); chk("R1 capture", d, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ur", 32'(ur_pulse), 0);
    chk("R1 ready", 32'(msg_ready), 1);

    // R2/R3 first capture
    msg_valid = 1; msg_type = 0; msg_hdr = mk_hdr(1);
    tick();
    msg_valid = 0;
    rd(12'h348, d); chk("R3 bytes 8-11", d, 32'h191a1b1c);
    rd(A_STAT, d); chk("R2 status set", d, 1);
    for (int w = 0; w < 4; w++) begin
      rd(A_CAP + 12'(4*w), d); chk("R2 capture word", d, word_of(1, w));
    end
    chk("R6 irq set", 32'(irq), 1);

    // R4 stall
    msg_valid = 1; msg_hdr = mk_hdr(2);
    #1 chk("R4 ready low", 32'(msg_ready), 0);
    tick(); tick();
    rd(A_CAP, d); chk("R4 capture held", d, word_of(1, 0));

    // R9 read-only capture
    wr(12'h344, 32'hdeadbeef);
    rd(12'h344, d); chk("R9 write ignored", d, word_of(1, 1));

    // R5 clear semantics
    wr(A_STAT, 0);
    rd(A_STAT, d); chk("R5 write zero", d, 1);
    wr(A_STAT, 1);
    rd(A_STAT, d); chk("R5 cleared", d, 0);
    chk("R5 ready after clear", 32'(msg_ready), 1);
    tick();
    msg_valid = 0;
    rd(12'h34c, d); chk("R5 queued captured", d, word_of(2, 3));
    rd(A_STAT, d); chk("R5 status again", d, 1);

    // R10 clear and accept on the same edge
    wr(A_STAT, 1);
    msg_valid = 1; msg_hdr = mk_hdr(3);
    reg_wr = 1; reg_addr = A_STAT; reg_wdata = 1;
    tick();
    msg_valid = 0; reg_wr = 0;
    rd(A_STAT, d); chk("R10 status kept", d, 1);
    rd(A_CAP, d); chk("R10 captured", d, word_of(3, 0));

    // R11 mask and R6 masked irq
    wr(A_MASK, 1);
    rd(A_MASK, d); chk("R11 mask readback", d, 1);
    rd(12'h300, d); chk("R11 other address", d, 0);
    chk("R6 irq masked", 32'(irq), 0);

    // R7 masked Type 0
    msg_valid = 1; msg_type = 0; msg_hdr = mk_hdr(4);
    #1 chk("R7 ready masked", 32'(msg_ready), 1);
    tick();
    msg_valid = 0;
    chk("R7 ur high", 32'(ur_pulse), 1);
    rd(A_CAP, d); chk("R7 no capture", d, word_of(3, 0));
    tick();
    chk("R7 ur one cycle", 32'(ur_pulse), 0);

    // R8 masked Type 1
    msg_valid = 1; msg_type = 1; msg_hdr = mk_hdr(5);
    tick();
    msg_valid = 0;
    chk("R8 no ur", 32'(ur_pulse), 0);
    rd(12'h344, d); chk("R8 no capture", d, word_of(3, 1));
    rd(A_STAT, d); chk("R8 status same", d, 1);

    // R12 mask write on the acceptance edge uses old mask
    wr(A_MASK, 0);
    chk("R6 irq unmasked", 32'(irq), 1);
    wr(A_STAT, 1);
    msg_valid = 1; msg_type = 0; msg_hdr = mk_hdr(6);
    reg_wr = 1; reg_addr = A_MASK; reg_wdata = 1;
    tick();
    msg_valid = 0; reg_wr = 0;
    rd(A_CAP, d); chk("R12 captured under old mask", d, word_of(6, 0));
    chk("R12 no ur", 32'(ur_pulse), 0);
    wr(A_MASK, 0);
    wr(A_STAT, 1);

    // Random traffic checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      msg_valid = ($urandom_range(0, 1) == 1);
      msg_type  = ($urandom_range(0, 1) == 1);
      msg_hdr   = mk_hdr($urandom_range(0, 200));
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom();
      case ($urandom_range(0, 6))
        0: reg_addr = A_STAT;
        1: reg_addr = A_MASK;
        2: reg_addr = 12'h340;
        3: reg_addr = 12'h344;
        4: reg_addr = 12'h348;
        5: reg_addr = 12'h34c;
        default: reg_addr = 12'h300;
      endcase
      tick();
    end
    msg_valid = 0; reg_wr = 0;
    tick();
    finish_run();
  end

endmodule